// File: doc/BRIEF.md
# Sixteen-Input External Interrupt Edge Unit

This block watches sixteen asynchronous interrupt pins. Each pin passes through a two-stage synchronizer. The synchronized level is compared with the sample from the cycle before, and an edge that the per-pin sensitivity allows sets a sticky status flag. Software picks rising, falling or both edges for each pin. It enables the pin's request output and clears flags and overrun bits by writing ones to them.

Pins 4 to 15 share one interrupt request line. Each of pins 0 to 3 has its own interrupt request line and its own DMA request line, and a per-pin steering bit selects which of the two the flag drives. A DMA acknowledge clears the flag of a pin that is in DMA mode. If a qualifying edge arrives while a pin's flag is still set, the pin's overrun bit is set. A combined overrun output is high while any overrun bit is set.

Register access uses a simple port. A write takes effect in the cycle that `reg_wr` is high. Read data is combinational from `reg_addr`.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset all flags, overrun bits and configuration registers are zero, and `irq_req_lo`, `dma_req`, `irq_req_hi` and `ovr_any` are all low.
- R2: Register map by `reg_addr`: 0 is the flags, 1 is the overrun bits, 2 is the rising-edge enables, 3 is the falling-edge enables, 4 is the request enables, and 5 is the DMA steering bits in bits 3:0, with bits 15:4 reading as zero. Bit n of each register belongs to pin n. Addresses 6 and 7 read as zero.
- R3: A pin level change sets flag n only if it is a rise with rising enable n set, or a fall with falling enable n set. Setting both enables catches both directions.
- R4: The flag becomes visible on the third rising clock edge after the pin changes, not earlier.
- R5: Flags are sticky. Writing one to a bit at address 0 clears that flag, and a written zero has no effect. If a clearing write and a new edge fall in the same cycle, the flag stays set.
- R6: A qualifying edge on a pin whose flag is already set sets that pin's overrun bit. Overrun bits are cleared by writing one at address 1. `ovr_any` is the OR of all overrun bits.
- R7: `irq_req_hi` is high when any of pins 4 to 15 has both its flag and its request enable set.
- R8: For pin n in 0 to 3 with flag and request enable set, `dma_req[n]` is driven if steering bit n is 1, and `irq_req_lo[n]` is driven otherwise. The two are never high together.
- R9: A cleared request enable holds the request output low, but the flag still sets.
- R10: `dma_ack[n]` clears flag n only when steering bit n is 1. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 16 | Asynchronous interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| dma_ack | input | 4 | DMA acknowledge for pins 0 to 3 |
| irq_req_lo | output | 4 | Interrupt requests of pins 0 to 3 |
| dma_req | output | 4 | DMA requests of pins 0 to 3 |
| irq_req_hi | output | 1 | Shared interrupt request of pins 4 to 15 |
| ovr_any | output | 1 | OR of all overrun bits |

## Verification
The directed cases cover each edge-sensitivity setting:
- A lone rise or fall under rising-only, falling-only, both and neither shows whether direction is decoded per pin.
- A change watched cycle by cycle pins the three-edge latency.

Further directed cases cover interactions between flags, writes and edges:
- A clearing write landing in the same cycle as a new edge separates a correct set-wins priority from a clear-wins one.
- A repeated edge before clearing shows that overrun is tied to the existing flag.

Random pin vectors, under random sensitivity, enable and steering settings, mix many pins at once. Checking them against a bench model shows that pins do not disturb one another, and shows how the low pins split between interrupt and DMA, including acknowledges sent to pins not in DMA mode.

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit #(
  parameter int N_IN = 16,
  parameter int N_LO = 4,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_pin,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [N_IN-1:0] reg_wdata,
  output logic [N_IN-1:0] reg_rdata,
  input  logic [N_LO-1:0] dma_ack,
  output logic [N_LO-1:0] irq_req_lo,
  output logic [N_LO-1:0] dma_req,
  output logic            irq_req_hi,
  output logic            ovr_any
);
  localparam int N_HI = N_IN - N_LO;

  logic [N_IN-1:0] sync1, sync2, prev;
  logic [N_IN-1:0] flags, ovr, rise_en, fall_en, req_en;
  logic [N_LO-1:0] dma_sel;
  logic [N_IN-1:0] hit, flag_clr, ovr_clr, active;

  assign hit = (sync2 & ~prev & rise_en) | (~sync2 & prev & fall_en);
  assign flag_clr = ((reg_wr && reg_addr == AW'(0)) ? reg_wdata : '0)
                  | {{N_HI{1'b0}}, dma_ack & dma_sel};
  assign ovr_clr  = (reg_wr && reg_addr == AW'(1)) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
      flags <= '0; ovr <= '0;
      rise_en <= '0; fall_en <= '0; req_en <= '0; dma_sel <= '0;
    end else begin
      sync1 <= irq_pin;
      sync2 <= sync1;
      prev  <= sync2;
      flags <= (flags & ~flag_clr) | hit;
      ovr   <= (ovr & ~ovr_clr) | (hit & flags);
      if (reg_wr) begin
        case (reg_addr)
          AW'(2): rise_en <= reg_wdata;
          AW'(3): fall_en <= reg_wdata;
          AW'(4): req_en  <= reg_wdata;
          AW'(5): dma_sel <= reg_wdata[N_LO-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(0):  reg_rdata = flags;
      AW'(1):  reg_rdata = ovr;
      AW'(2):  reg_rdata = rise_en;
      AW'(3):  reg_rdata = fall_en;
      AW'(4):  reg_rdata = req_en;
      AW'(5):  reg_rdata = {{N_HI{1'b0}}, dma_sel};
      default: reg_rdata = '0;
    endcase
  end

  assign active     = flags & req_en;
  assign irq_req_lo = active[N_LO-1:0] & ~dma_sel;
  assign dma_req    = active[N_LO-1:0] & dma_sel;
  assign irq_req_hi = |active[N_IN-1:N_LO];
  assign ovr_any    = |ovr;

  // New flag bits only where the synchronized sample changed a cycle earlier
  assert_flag_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~($past(sync2) ^ $past(prev))) == '0));

  // A set flag survives any cycle with no clear request
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == '0));

  // Overrun only appears on a pin whose flag was already set
  assert_ovr_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovr & ~$past(ovr) & ~$past(flags)) == '0));

  assert_req_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_lo & dma_req) == '0);

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req_lo | dma_req) & ~req_en[N_LO-1:0]) == '0);

  // An acknowledged DMA request is gone next cycle unless a fresh edge re-set it
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_ack & dma_req & ~hit[N_LO-1:0])) |=> ((dma_req & $past(dma_ack & dma_req & ~hit[N_LO-1:0])) == '0));
endmodule

// File: tb/test_ext_irq_edge_unit.sv
module test_ext_irq_edge_unit;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] irq_pin = '0, reg_wdata = '0, reg_rdata;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  dma_ack = '0, irq_req_lo, dma_req;
  logic        irq_req_hi, ovr_any;

  ext_irq_edge_unit i_ext_irq_edge_unit (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_ack(dma_ack),
    .irq_req_lo(irq_req_lo), .dma_req(dma_req), .irq_req_hi(irq_req_hi), .ovr_any(ovr_any));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_flag = '0, m_ovr = '0, m_rise = '0, m_fall = '0, m_en = '0, m_pin = '0;
  logic [3:0]  m_sel = '0;

  function automatic logic [15:0] edges_of(logic [15:0] o, logic [15:0] n, logic [15:0] r, logic [15:0] f);
    return (~o & n & r) | (o & ~n & f);
  endfunction
  function automatic logic [3:0] exp_lo();
    return m_flag[3:0] & m_en[3:0] & ~m_sel;
  endfunction
  function automatic logic [3:0] exp_dma();
    return m_flag[3:0] & m_en[3:0] & m_sel;
  endfunction
  function automatic logic exp_hi();
    return |(m_flag[15:4] & m_en[15:4]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
    case (a)
      3'd0: m_flag &= ~d;
      3'd1: m_ovr &= ~d;
      3'd2: m_rise = d;
      3'd3: m_fall = d;
      3'd4: m_en = d;
      3'd5: m_sel = d[3:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pins(logic [15:0] v);
    logic [15:0] e;
    @(negedge clk); irq_pin = v;
    e = edges_of(m_pin, v, m_rise, m_fall);
    m_pin = v;
    repeat (3) @(posedge clk);
    m_ovr |= e & m_flag;
    m_flag |= e;
  endtask

  task automatic check_all(string tag);
    logic [15:0] d;
    rd(3'd0, d); chk({tag, " R3 flags"}, d, m_flag);
    rd(3'd1, d); chk({tag, " R6 overrun"}, d, m_ovr);
    chk({tag, " R6 ovr_any"}, ovr_any, |m_ovr);
    chk({tag, " R8 irq_req_lo"}, irq_req_lo, exp_lo());
    chk({tag, " R8 dma_req"}, dma_req, exp_dma());
    chk({tag, " R7 irq_req_hi"}, irq_req_hi, exp_hi());
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d); chk("R1 reset register", d, 16'h0);
    end
    chk("R1 reset outputs", {irq_req_lo, dma_req, irq_req_hi, ovr_any}, 10'h0);

    // R2 register map and readback
    wr(3'd2, 16'hA5C3); wr(3'd3, 16'h3C5A); wr(3'd4, 16'h0F0F); wr(3'd5, 16'hFFF6);
    rd(3'd2, d); chk("R2 rise readback", d, 16'hA5C3);
    rd(3'd3, d); chk("R2 fall readback", d, 16'h3C5A);
    rd(3'd4, d); chk("R2 enable readback", d, 16'h0F0F);
    rd(3'd5, d); chk("R2 steering readback", d, 16'h0006);
    rd(3'd6, d); chk("R2 unmapped read", d, 16'h0);
    rd(3'd7, d); chk("R2 unmapped read", d, 16'h0);

    // R3 edge direction: pin0 rise only, pin1 fall only, pin2 both, pin3 none
    wr(3'd2, 16'h0005); wr(3'd3, 16'h0006); wr(3'd4, 16'h0); wr(3'd5, 16'h0);
    pins(16'h000F); check_all("rise");
    chk("R3 rise set pins 0 and 2", m_flag, 16'h0005);
    wr(3'd0, 16'hFFFF);
    pins(16'h0000); check_all("fall");
    chk("R3 fall set pins 1 and 2", m_flag, 16'h0006);
    wr(3'd0, 16'hFFFF);

    // R4 latency: flag visible only on the third edge
    wr(3'd2, 16'h0100);
    @(negedge clk); irq_pin = 16'h0100; m_pin = 16'h0100;
    @(posedge clk); @(negedge clk); reg_addr = 3'd0; #1 chk("R4 not after edge 1", reg_rdata, 16'h0);
    @(posedge clk); @(negedge clk); #1 chk("R4 not after edge 2", reg_rdata, 16'h0);
    @(posedge clk); @(negedge clk); #1 chk("R4 set after edge 3", reg_rdata, 16'h0100);
    m_flag = 16'h0100;

    // R5 a zero write leaves the flag alone
    wr(3'd0, 16'hFEFF); rd(3'd0, d); chk("R5 zero write no effect", d, 16'h0100);

    // R6 overrun: second edge while flag set
    wr(3'd3, 16'h0100);
    pins(16'h0000); check_all("overrun");
    chk("R6 overrun expected set", m_ovr, 16'h0100);
    wr(3'd1, 16'h0100); rd(3'd1, d); chk("R6 overrun cleared", d, 16'h0);
    chk("R6 ovr_any low", ovr_any, 1'b0);

    // R5 set wins over a same-cycle clear
    @(negedge clk); irq_pin = 16'h0100; m_pin = 16'h0100;
    @(posedge clk); @(negedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd0; reg_wdata = 16'h0100;
    @(posedge clk); #1 reg_wr = 0;
    m_ovr |= 16'h0100;
    rd(3'd0, d); chk("R5 set wins over clear", d, 16'h0100);
    rd(3'd1, d); chk("R6 overrun on same-cycle case", d, 16'h0100);
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'hFFFF);

    // R9 disabled request stays low yet flag sets; R7 shared line
    wr(3'd4, 16'h0000);
    pins(16'h0000); pins(16'h0100); check_all("gated");
    chk("R9 flag sets while gated", m_flag[8], 1'b1);
    chk("R9 hi request held low", irq_req_hi, 1'b0);
    wr(3'd4, 16'h0100); #1 chk("R7 hi request on enable", irq_req_hi, 1'b1);
    wr(3'd0, 16'hFFFF);

    // R8 / R10 steering and acknowledge
    wr(3'd2, 16'h0003); wr(3'd3, 16'h0); wr(3'd4, 16'h000F); wr(3'd5, 16'h0002);
    pins(16'h0103); check_all("steer");
    chk("R8 pin0 to interrupt", irq_req_lo, 4'b0001);
    chk("R8 pin1 to DMA", dma_req, 4'b0010);
    @(negedge clk); dma_ack = 4'b0011; @(posedge clk); #1 dma_ack = 4'b0;
    m_flag &= ~16'h0002;
    rd(3'd0, d); chk("R10 ack clears DMA pin only", d & 16'h0003, 16'h0001);
    wr(3'd0, 16'hFFFF);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      if (it % 6 == 0) begin
        wr(3'd2, 16'($urandom())); wr(3'd3, 16'($urandom()));
        wr(3'd4, 16'($urandom())); wr(3'd5, 16'($urandom()));
      end
      pins(16'($urandom()));
      check_all("random");
      if ($urandom() % 2) wr(3'd0, 16'($urandom()));
      if ($urandom() % 2) wr(3'd1, 16'($urandom()));
      if ($urandom() % 2) begin
        logic [3:0] a;
        a = 4'($urandom());
        @(negedge clk); dma_ack = a; @(posedge clk); #1 dma_ack = 4'b0;
        m_flag &= ~{12'h0, a & m_sel};
      end
      check_all("random R10");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule